// File: doc/BRIEF.md
# SPI Serial Flash Read Responder

This block acts as the slave side of a serial NOR flash command port. A host selects it by pulling `cs_n` low, clocks an opcode and any following bytes in on `mosi`, and receives data back on `miso`. The read command takes a 24-bit address and returns bytes from an internal byte array. The address advances after each byte, so a single command can stream through the whole array and wrap around. The host stops the stream by raising `cs_n`.

A status write command stores one byte into the status register. It comes in two forms. The plain form models a non-volatile write: the block reports itself busy for a fixed number of system clocks. The volatile form is armed by a one-byte enable command immediately before it, and it updates the register without raising busy. While busy, read commands are dropped.

The serial pins are oversampled by the system clock `clk`. Each SCK phase must last at least six `clk` cycles. A backdoor port fills the array and can hold the busy flag high.

Top module: `spi_flash_rd`

## Requirements
- R1: After reset, `status` is 00h, `busy` is 0 and `miso_oe` is 0.
- R2: Opcode 03h followed by a 24-bit address, both sent MSB first and sampled on SCK rising edges, returns the byte at that address on `miso`. Its MSB comes first, and each bit changes only after an SCK falling edge.
- R3: After each returned byte the address advances by one, so bytes keep streaming for as long as SCK runs and `cs_n` stays low.
- R4: The address counter wraps from MEM_BYTES-1 to 0. Address bits at and above log2(MEM_BYTES) are ignored.
- R5: `miso_oe` is 0 while the opcode and address are being received and whenever `cs_n` is high. It is 1 during the data phase of a read.
- R6: Reads work the same whether SCK idles low (mode 0) or high (mode 3) when `cs_n` falls.
- R7: A read opcode received while `busy` is 1 is dropped. `miso_oe` stays 0 until `cs_n` rises, and the busy countdown in progress is unaffected.
- R8: Opcode 01h followed by 8 data bits, with no arming command before it, loads those bits into `status` after `cs_n` rises. It holds `busy` at 1 for WR_CYCLES system clocks.
- R9: Opcode 50h in one transaction followed by 01h plus a data byte in the next loads `status` without `busy` ever rising.
- R10: The arming set by 50h is cancelled when any opcode other than 01h completes, so a later 01h behaves as in R8.
- R11: Raising `cs_n` mid-command discards a partial opcode or address. A status write with fewer than 8 data bits leaves `status` unchanged, and data bits after the eighth are ignored.
- R12: `status` changes only at the end of a complete status write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| miso_oe | output | 1 | Output enable for `miso`; 0 means high impedance |
| bd_we | input | 1 | Backdoor array write strobe |
| bd_addr | input | log2(MEM_BYTES) | Backdoor write address |
| bd_wdata | input | 8 | Backdoor write data |
| bd_busy | input | 1 | Forces busy high while 1 |
| busy | output | 1 | Busy flag; reads are refused while set |
| status | output | 8 | Current status register value |

## Verification
Two events can land in the same window. One is a read opcode completing. The other is the busy countdown from a non-volatile status write, still running. The bench provokes this by issuing a full read command straight after a plain status write. It then judges that `miso_oe` never rises during that read, that `busy` is still high once the read ends, and that busy drops only near the expected WR_CYCLES count. A second pairing sets a volatile status write against busy. Here `busy` is sampled on every clock after the commit, and it must stay low.

// File: rtl/spi_flash_rd_pkg.sv
package spi_flash_rd_pkg;
  typedef enum logic [2:0] {
    ST_OPC,
    ST_ADR,
    ST_DAT,
    ST_SWR,
    ST_SKIP
  } fsm_t;

  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_VOLEN = 8'h50;
endpackage

// File: rtl/flash_resp_sync.sv
module flash_resp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  output logic cs_s,
  output logic si_s,
  output logic sck_rise,
  output logic sck_fall
);
  logic [STAGES-1:0] cs_p, sck_p, si_p;
  logic sck_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_p  <= '1;
      sck_p <= '0;
      si_p  <= '0;
      sck_d <= 1'b0;
    end else begin
      cs_p  <= {cs_p[STAGES-2:0], cs_n};
      sck_p <= {sck_p[STAGES-2:0], sck};
      si_p  <= {si_p[STAGES-2:0], si};
      sck_d <= sck_p[STAGES-1];
    end
  end

  assign cs_s     = cs_p[STAGES-1];
  assign si_s     = si_p[STAGES-1];
  assign sck_rise = sck_p[STAGES-1] & ~sck_d;
  assign sck_fall = ~sck_p[STAGES-1] & sck_d;
endmodule

// File: rtl/flash_resp_mem.sv
module flash_resp_mem #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/spi_flash_rd.sv
module spi_flash_rd
  import spi_flash_rd_pkg::*;
#(
  parameter int MEM_BYTES   = 256,
  parameter int ADDR_BITS   = 24,
  parameter int WR_CYCLES   = 64,
  parameter int SYNC_STAGES = 2,
  localparam int AW = $clog2(MEM_BYTES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          sck,
  input  logic          mosi,
  output logic          miso,
  output logic          miso_oe,
  input  logic          bd_we,
  input  logic [AW-1:0] bd_addr,
  input  logic [7:0]    bd_wdata,
  input  logic          bd_busy,
  output logic          busy,
  output logic [7:0]    status
);
  localparam int CW = $clog2(ADDR_BITS);
  localparam int NW = $clog2(WR_CYCLES + 1);

  logic cs_s, si_s, sck_r, sck_f;

  flash_resp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .sck      (sck),
    .si       (mosi),
    .cs_s     (cs_s),
    .si_s     (si_s),
    .sck_rise (sck_r),
    .sck_fall (sck_f)
  );

  fsm_t                 state;
  logic [CW-1:0]        bcnt;
  logic [ADDR_BITS-1:0] sh, sh_nx;
  logic [AW-1:0]        addr;
  logic [7:0]           mem_q, out_sh, sw_byte, status_q, opc_byte;
  logic [2:0]           obit;
  logic [3:0]           swcnt;
  logic [NW-1:0]        nv_cnt;
  logic                 vol_en, wr_vol, busy_q, miso_q, oe_q;
  logic                 rise, fall, opc_done, commit, dfall;

  flash_resp_mem #(.DEPTH(MEM_BYTES)) u_mem (
    .clk   (clk),
    .we    (bd_we),
    .waddr (bd_addr),
    .wdata (bd_wdata),
    .raddr (addr),
    .rdata (mem_q)
  );

  assign rise     = sck_r & ~cs_s;
  assign fall     = sck_f & ~cs_s;
  assign sh_nx    = {sh[ADDR_BITS-2:0], si_s};
  assign opc_byte = sh_nx[7:0];
  assign opc_done = rise && (state == ST_OPC) && (bcnt == CW'(7));
  assign dfall    = fall && (state == ST_DAT);
  assign commit   = cs_s && (state == ST_SWR) && (swcnt == 4'd8);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_OPC;
      bcnt     <= '0;
      sh       <= '0;
      addr     <= '0;
      out_sh   <= '0;
      sw_byte  <= '0;
      status_q <= '0;
      obit     <= '0;
      swcnt    <= '0;
      nv_cnt   <= '0;
      vol_en   <= 1'b0;
      wr_vol   <= 1'b0;
      busy_q   <= 1'b0;
      miso_q   <= 1'b0;
      oe_q     <= 1'b0;
    end else begin
      busy_q <= bd_busy | (nv_cnt != '0);
      if (commit) begin
        status_q <= sw_byte;
        if (!wr_vol) nv_cnt <= NW'(WR_CYCLES);
      end else if (nv_cnt != '0) begin
        nv_cnt <= nv_cnt - 1'b1;
      end

      if (cs_s) begin
        state <= ST_OPC;
        bcnt  <= '0;
        oe_q  <= 1'b0;
      end else begin
        case (state)
          ST_OPC: if (rise) begin
            sh <= sh_nx;
            if (bcnt == CW'(7)) begin
              bcnt   <= '0;
              vol_en <= (opc_byte == OP_VOLEN);
              case (opc_byte)
                OP_READ: state <= busy_q ? ST_SKIP : ST_ADR;
                OP_WRSR: begin
                  state  <= ST_SWR;
                  wr_vol <= vol_en;
                  swcnt  <= '0;
                end
                default: state <= ST_SKIP;
              endcase
            end else begin
              bcnt <= bcnt + 1'b1;
            end
          end
          ST_ADR: if (rise) begin
            sh <= sh_nx;
            if (bcnt == CW'(ADDR_BITS - 1)) begin
              addr  <= sh_nx[AW-1:0];
              obit  <= '0;
              state <= ST_DAT;
            end else begin
              bcnt <= bcnt + 1'b1;
            end
          end
          ST_DAT: if (fall) begin
            oe_q <= 1'b1;
            obit <= obit + 1'b1;
            if (obit == 3'd0) begin
              miso_q <= mem_q[7];
              out_sh <= {mem_q[6:0], 1'b0};
              addr   <= addr + 1'b1;
            end else begin
              miso_q <= out_sh[7];
              out_sh <= {out_sh[6:0], 1'b0};
            end
          end
          ST_SWR: if (rise && (swcnt != 4'd8)) begin
            sw_byte <= {sw_byte[6:0], si_s};
            swcnt   <= swcnt + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign miso    = miso_q;
  assign miso_oe = oe_q;
  assign busy    = busy_q;
  assign status  = status_q;
endmodule

// File: rtl/spi_flash_rd_chk.sv
module spi_flash_rd_chk
  import spi_flash_rd_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input fsm_t       state,
  input logic       bcnt_zero,
  input logic       cs_s,
  input logic       miso,
  input logic       miso_oe,
  input logic       dfall,
  input logic       opc_done,
  input logic [7:0] opc_byte,
  input logic       busy_q,
  input logic       commit,
  input logic       wr_vol,
  input logic       bd_busy,
  input logic       nv_idle,
  input logic [7:0] status
);
  // R5: no drive outside the data phase
  a_r5_oe_quiet: assert property (@(posedge clk) disable iff (rst)
    (state != ST_DAT) |-> !miso_oe);

  // R2: serial output moves only on a qualified falling edge
  a_r2_miso_on_fall: assert property (@(posedge clk) disable iff (rst)
    !dfall |=> $stable(miso));

  // R7: read refused while busy
  a_r7_busy_read_dropped: assert property (@(posedge clk) disable iff (rst)
    (opc_done && (opc_byte == OP_READ) && busy_q) |=> (state == ST_SKIP));

  // R8: plain status write raises busy
  a_r8_nv_busy: assert property (@(posedge clk) disable iff (rst)
    (commit && !wr_vol) |=> ##1 busy_q);

  // R9: volatile status write leaves busy low
  a_r9_vol_no_busy: assert property (@(posedge clk) disable iff (rst)
    (commit && wr_vol && !bd_busy && nv_idle) |=> !busy_q);

  // R11: deselect returns to opcode reception
  a_r11_cs_clears: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> ((state == ST_OPC) && bcnt_zero));

  // R12: status only changes on commit
  a_r12_status_hold: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(status));
endmodule

bind spi_flash_rd spi_flash_rd_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .state     (state),
  .bcnt_zero (bcnt == '0),
  .cs_s      (cs_s),
  .miso      (miso),
  .miso_oe   (miso_oe),
  .dfall     (dfall),
  .opc_done  (opc_done),
  .opc_byte  (opc_byte),
  .busy_q    (busy_q),
  .commit    (commit),
  .wr_vol    (wr_vol),
  .bd_busy   (bd_busy),
  .nv_idle   (nv_cnt == '0),
  .status    (status)
);

// File: tb/spi_flash_rd_test.sv
`timescale 1ns/1ps
module spi_flash_rd_test;
  localparam int MEM_BYTES = 256;
  localparam int AW        = 8;
  localparam int WR_CYC    = 2000;
  localparam int HALF      = 40;

  logic clk = 1'b0, rst = 1'b1, cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic bd_we = 1'b0, bd_busy = 1'b0;
  logic [AW-1:0] bd_addr = '0;
  logic [7:0] bd_wdata = '0;
  logic miso, miso_oe, busy;
  logic [7:0] status;
  logic mode3 = 1'b0;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  spi_flash_rd #(.MEM_BYTES(MEM_BYTES), .WR_CYCLES(WR_CYC)) uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .bd_we(bd_we), .bd_addr(bd_addr),
    .bd_wdata(bd_wdata), .bd_busy(bd_busy), .busy(busy), .status(status)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'(((a % MEM_BYTES) * 37) + 11);
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cs_open(input logic m3);
    mode3 = m3; sck = m3; #(HALF);
    cs_n = 1'b0; #(HALF);
  endtask

  task automatic cs_close();
    if (!mode3) sck = 1'b0;
    #(HALF);
    cs_n = 1'b1; #(HALF*3);
  endtask

  task automatic shift(input int n, input logic [31:0] tx,
                       output logic [31:0] rx, output logic oe_any);
    rx = '0; oe_any = 1'b0;
    for (int i = n - 1; i >= 0; i--) begin
      sck = 1'b0; mosi = tx[i]; #(HALF);
      rx = {rx[30:0], miso};
      oe_any |= miso_oe;
      sck = 1'b1; #(HALF);
    end
  endtask

  task automatic cmd(input logic m3, input int n, input logic [31:0] tx);
    logic [31:0] rx; logic oe;
    cs_open(m3); shift(n, tx, rx, oe); cs_close();
  endtask

  task automatic do_read(input logic m3, input logic [23:0] a, input int nbytes,
                         input string req);
    logic [31:0] rx; logic oe;
    cs_open(m3);
    shift(8, 32'h03, rx, oe);            chk("R5", "oe in opcode", oe, 0);
    shift(24, {8'h00, a}, rx, oe);       chk("R5", "oe in address", oe, 0);
    for (int b = 0; b < nbytes; b++) begin
      shift(8, 32'h0, rx, oe);
      chk(req, "read byte", rx[7:0], pat(int'(a) + b));
      if (b == 0) chk("R5", "oe in data", oe, 1);
    end
    cs_close();
    chk("R5", "oe after deselect", miso_oe, 0);
  endtask

  task automatic blocked_read(input string req);
    logic [31:0] rx; logic oe, oe_all;
    cs_open(1'b0);
    shift(8, 32'h03, rx, oe);        oe_all = oe;
    shift(24, 32'h000040, rx, oe);   oe_all |= oe;
    shift(16, 32'h0, rx, oe);        oe_all |= oe;
    cs_close();
    chk(req, "read while busy drives nothing", oe_all, 0);
  endtask

  task automatic wait_idle(input string req, output int n);
    n = 0;
    while (busy && n < 5000) begin @(negedge clk); n++; end
    chk(req, "busy released", busy, 0);
  endtask

  initial begin
    int n;
    logic [31:0] rx;
    logic oe, busy_seen;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk("R1", "status at reset", status, 8'h00);
    chk("R1", "busy at reset", busy, 0);
    chk("R1", "oe at reset", miso_oe, 0);

    for (int i = 0; i < MEM_BYTES; i++) begin
      bd_we = 1'b1; bd_addr = AW'(i); bd_wdata = pat(i);
      @(negedge clk);
    end
    bd_we = 1'b0;
    repeat (4) @(negedge clk);

    // R2 basic read, mode 0 and mode 3 (R6)
    do_read(1'b0, 24'h000010, 4, "R2");
    do_read(1'b1, 24'h000033, 3, "R6");
    // R4 wrap and ignored upper bits, mode 3
    do_read(1'b1, 24'h0000FE, 5, "R4");
    do_read(1'b0, 24'hABCDF0, 20, "R4");
    // R3 whole array plus wrap in one command
    do_read(1'b0, 24'h000000, MEM_BYTES + 4, "R3");
    // R6 sweep of start addresses alternating modes
    for (int s = 0; s < MEM_BYTES; s += 15)
      do_read(1'((s / 15) % 2), 24'(s), 2, "R6");

    // R7 forced busy
    bd_busy = 1'b1; repeat (4) @(negedge clk);
    chk("R7", "forced busy visible", busy, 1);
    blocked_read("R7");
    bd_busy = 1'b0; repeat (4) @(negedge clk);
    do_read(1'b0, 24'h000040, 2, "R7");

    // R8 plain status write, read refused during countdown
    cmd(1'b0, 16, 32'h01A5);
    chk("R8", "status after plain write", status, 8'hA5);
    chk("R8", "busy after plain write", busy, 1);
    blocked_read("R7");
    chk("R7", "countdown still running", busy, 1);
    wait_idle("R8", n);
    chk("R8", "countdown length", (n > WR_CYC - 1000) && (n < WR_CYC), 1);

    // R9 volatile write keeps busy low
    cmd(1'b0, 8, 32'h50);
    cs_open(1'b0); shift(16, 32'h013C, rx, oe);
    if (!mode3) sck = 1'b0;
    #(HALF); cs_n = 1'b1;
    busy_seen = 1'b0;
    for (int k = 0; k < 60; k++) begin @(negedge clk); busy_seen |= busy; end
    chk("R9", "status after volatile write", status, 8'h3C);
    chk("R9", "busy stayed low", busy_seen, 0);

    // R10 another opcode cancels the arming
    cmd(1'b1, 8, 32'h50);
    cmd(1'b1, 8, 32'h00);
    cmd(1'b1, 16, 32'h0177);
    chk("R10", "status", status, 8'h77);
    chk("R10", "write became plain", busy, 1);
    wait_idle("R10", n);

    // R11 partial transfers
    cmd(1'b0, 13, 32'h0035);
    chk("R11", "short status write ignored", status, 8'h77);
    chk("R12", "no busy from short write", busy, 0);
    cmd(1'b0, 4, 32'h0);
    do_read(1'b0, 24'h000021, 2, "R11");
    cs_open(1'b0); shift(8, 32'h03, rx, oe); shift(12, 32'hFFF, rx, oe); cs_close();
    do_read(1'b1, 24'h000077, 2, "R11");
    cmd(1'b0, 24, 32'h0112FF);
    chk("R11", "bits after eighth ignored", status, 8'h12);
    wait_idle("R11", n);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule